// File: doc/BRIEF.md
# Asynchronous NAND Bus Strobe Controller

This block turns single requests from a host into one access on an 8-bit asynchronous NAND flash bus. Each request carries a kind (command, address, data write or data read) and, for writes, a byte. The block runs the access through a setup phase, a strobe phase and a hold phase. It keeps chip enable asserted across all three phases and pulses the write or read strobe only in the middle one. Command and address accesses raise the matching latch-enable line. When the direction of transfer flips between accesses, a few idle bus cycles are inserted first.

All timing comes from one packed 32-bit configuration word. Reads and writes have separate setup, strobe and hold counts, and there is one turnaround count. A phase programmed with value v lasts v+1 clock cycles. With a clock of about 13 ns, the example word (write setup 1, write strobe 3, write hold 1, read setup 1, read strobe 5, read hold 1, turnaround 3) gives roughly 26 ns of setup and hold, a 52 ns write strobe and a 78 ns read strobe. This meets the flash minimums of about 10 ns, 40 ns and 60 ns.

The host raises a request and holds it until a one-cycle acknowledge. For reads, the captured byte is valid from the acknowledge onward. A synchronized copy of the device ready/busy line is reported separately.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: In reset and right after it, chip enable, write strobe and read strobe are high (inactive), both latch enables are low, the data bus is not driven, acknowledge is low and ready reads 0.
- R2: Configuration fields: write setup 29:26, write strobe 25:20, write hold 19:17, read setup 16:13, read strobe 12:7, read hold 6:4, turnaround 3:2. Bits 31:30 and the bus-size field 1:0 must be 0 (8-bit bus, plain strobe mode, no wait extension).
- R3: A write-direction access (kind 0, 1 or 2) has a setup of wsetup+1 cycles, a write strobe of wstrobe+1 cycles and a hold of whold+1 cycles. Chip enable is low through all three phases, write strobe is low only in the strobe phase, and read strobe stays high.
- R4: A read access (kind 3) uses the read setup, strobe and hold counts in the same way, with the read strobe low only in its strobe phase and the write strobe high.
- R5: Kind encoding is 0 command, 1 address, 2 data write, 3 data read. Command drives CLE=1 and ALE=0, address drives ALE=1 and CLE=0, and data accesses keep both low.
- R6: During a write-direction access the byte is driven with output enable high. During a read access the output enable stays low.
- R7: A read returns the bus value present on the last cycle of the read strobe phase.
- R8: When an access's direction differs from the previous access's, turnaround+1 idle cycles with chip enable high precede its setup. No idle cycles are added after reset or between accesses of the same direction.
- R9: The acknowledge is a one-cycle pulse on the cycle after the last hold cycle. Kind, byte and request changes during a busy access or during the acknowledge cycle are ignored.
- R10: The ready output follows the ready/busy input (1 = ready) through two register stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 32 | Packed timing configuration word |
| req_i | input | 1 | Access request, held until acknowledge |
| kind_i | input | 2 | Access kind: 0 cmd, 1 addr, 2 write data, 3 read data |
| wdata_i | input | 8 | Byte for command, address or write data |
| ack_o | output | 1 | One-cycle access-complete pulse |
| rdata_o | output | 8 | Byte captured by the last read |
| ready_o | output | 1 | Synchronized device ready flag |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb_i | input | 1 | Device ready/busy, 1 = ready |

## Verification
A wrong phase counter or phase transition shows up within the same access. The measured run of strobe-low cycles, setup cycles or hold cycles differs from the configured value plus one, and the acknowledge arrives in the wrong cycle. A stale direction flag appears on the next access as missing or extra idle cycles before chip enable falls. A wrong kind latch corrupts CLE, ALE or the driven byte in the strobe where the flash samples them. A capture on the wrong strobe cycle returns a byte that differs from the value driven in the final strobe cycle.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  localparam int WSU_LSB = 26;
  localparam int WST_LSB = 20;
  localparam int WHD_LSB = 17;
  localparam int RSU_LSB = 13;
  localparam int RST_LSB = 7;
  localparam int RHD_LSB = 4;
  localparam int TA_LSB  = 2;

  localparam int SU_W = 4;
  localparam int ST_W = 6;
  localparam int HD_W = 3;
  localparam int TA_W = 2;
  localparam int CNT_W = ST_W;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_WDATA = 2'd2,
    KIND_RDATA = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_TURN, PH_SETUP, PH_STROBE, PH_HOLD
  } phase_e;

  typedef struct packed {
    logic [SU_W-1:0] wr_setup;
    logic [ST_W-1:0] wr_strobe;
    logic [HD_W-1:0] wr_hold;
    logic [SU_W-1:0] rd_setup;
    logic [ST_W-1:0] rd_strobe;
    logic [HD_W-1:0] rd_hold;
    logic [TA_W-1:0] turn;
  } timing_t;

endpackage

// File: rtl/nand_cfg_decode.sv
module nand_cfg_decode
  import nand_strobe_pkg::*;
(
  input  logic [31:0] cfg_i,
  output timing_t     tm_o,
  output logic        cfg_ok_o
);
  assign tm_o.wr_setup  = cfg_i[WSU_LSB +: SU_W];
  assign tm_o.wr_strobe = cfg_i[WST_LSB +: ST_W];
  assign tm_o.wr_hold   = cfg_i[WHD_LSB +: HD_W];
  assign tm_o.rd_setup  = cfg_i[RSU_LSB +: SU_W];
  assign tm_o.rd_strobe = cfg_i[RST_LSB +: ST_W];
  assign tm_o.rd_hold   = cfg_i[RHD_LSB +: HD_W];
  assign tm_o.turn      = cfg_i[TA_LSB +: TA_W];
  // strobe-mode, wait-extend and bus-size must stay zero
  assign cfg_ok_o = (cfg_i[31:30] == 2'b00) && (cfg_i[1:0] == 2'b00);
endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_strobe_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  timing_t       tm_i,
  input  logic          req_i,
  input  kind_e         kind_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] dq_i,
  output phase_e        phase_o,
  output kind_e         kind_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          ack_o
);
  phase_e           phase_q;
  kind_e            kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic             prev_vld_q, prev_rd_q;
  logic             rd_q, rd_new, sel_rd;
  logic [CNT_W-1:0] su_len, st_len, hd_len, ta_len;

  assign rd_q   = (kind_q == KIND_RDATA);
  assign rd_new = (kind_i == KIND_RDATA);
  assign sel_rd = (phase_q == PH_IDLE) ? rd_new : rd_q;

  always_comb begin
    su_len = sel_rd ? CNT_W'(tm_i.rd_setup)  : CNT_W'(tm_i.wr_setup);
    st_len = sel_rd ? CNT_W'(tm_i.rd_strobe) : CNT_W'(tm_i.wr_strobe);
    hd_len = sel_rd ? CNT_W'(tm_i.rd_hold)   : CNT_W'(tm_i.wr_hold);
    ta_len = CNT_W'(tm_i.turn);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      kind_q     <= KIND_CMD;
      cnt_q      <= '0;
      wdata_o    <= '0;
      rdata_o    <= '0;
      ack_o      <= 1'b0;
      prev_vld_q <= 1'b0;
      prev_rd_q  <= 1'b0;
    end else begin
      ack_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (req_i && !ack_o) begin
          kind_q  <= kind_i;
          wdata_o <= wdata_i;
          if (prev_vld_q && (prev_rd_q != rd_new)) begin
            phase_q <= PH_TURN;
            cnt_q   <= ta_len;
          end else begin
            phase_q <= PH_SETUP;
            cnt_q   <= su_len;
          end
        end
        PH_TURN: if (cnt_q == '0) begin
          phase_q <= PH_SETUP;
          cnt_q   <= su_len;
        end else cnt_q <= cnt_q - 1'b1;
        PH_SETUP: if (cnt_q == '0) begin
          phase_q <= PH_STROBE;
          cnt_q   <= st_len;
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (cnt_q == '0) begin
          if (rd_q) rdata_o <= dq_i;   // last strobe cycle
          phase_q <= PH_HOLD;
          cnt_q   <= hd_len;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_q == '0) begin
          phase_q    <= PH_IDLE;
          ack_o      <= 1'b1;
          prev_vld_q <= 1'b1;
          prev_rd_q  <= rd_q;
        end else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign kind_o  = kind_q;

  // R9: acknowledge never lasts two cycles
  a_r9_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R3: strobe phase is entered only from setup
  a_r3_strobe_after_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE && $past(phase_q) != PH_STROBE) |-> $past(phase_q) == PH_SETUP);
  // R8: idle turnaround is entered only from idle
  a_r8_turn_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_TURN && $past(phase_q) != PH_TURN) |-> $past(phase_q) == PH_IDLE);
  // R9: access kind is frozen while the bus is busy
  a_r9_kind_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(kind_q));
endmodule

// File: rtl/nand_strobe_ctrl.sv
module nand_strobe_ctrl
  import nand_strobe_pkg::*;
#(
  parameter int DW        = 8,
  parameter int RB_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [31:0]   cfg_i,
  input  logic          req_i,
  input  logic [1:0]    kind_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o,
  output logic          nand_ce_no,
  output logic          nand_we_no,
  output logic          nand_re_no,
  output logic          nand_cle_o,
  output logic          nand_ale_o,
  output logic [DW-1:0] nand_dq_o,
  output logic          nand_dq_oe_o,
  input  logic [DW-1:0] nand_dq_i,
  input  logic          nand_rb_i
);
  timing_t tm;
  logic    cfg_ok;
  phase_e  phase;
  kind_e   kind_q;
  logic    active, strobe, rd;

  nand_cfg_decode u_dec (
    .cfg_i    (cfg_i),
    .tm_o     (tm),
    .cfg_ok_o (cfg_ok)
  );

  nand_phase_seq #(.DW(DW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tm_i    (tm),
    .req_i   (req_i),
    .kind_i  (kind_e'(kind_i)),
    .wdata_i (wdata_i),
    .dq_i    (nand_dq_i),
    .phase_o (phase),
    .kind_o  (kind_q),
    .wdata_o (nand_dq_o),
    .rdata_o (rdata_o),
    .ack_o   (ack_o)
  );

  nand_rb_sync #(.STAGES(RB_STAGES)) u_rb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nand_rb_i),
    .q_o    (ready_o)
  );

  assign active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign strobe = (phase == PH_STROBE);
  assign rd     = (kind_q == KIND_RDATA);

  assign nand_ce_no   = !active;
  assign nand_we_no   = !(strobe && !rd);
  assign nand_re_no   = !(strobe && rd);
  assign nand_cle_o   = active && (kind_q == KIND_CMD);
  assign nand_ale_o   = active && (kind_q == KIND_ADDR);
  assign nand_dq_oe_o = active && !rd;

  // R2: only legal configuration words are used when a request is taken
  a_r2_cfg_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE && req_i && !ack_o) |-> cfg_ok);
  // R3: write strobe only inside chip enable
  a_r3_we_in_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_no |-> !nand_ce_no);
  // R4: never both strobes
  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!nand_we_no, !nand_re_no}) <= 1);
  // R5: latch enables are exclusive
  a_r5_latch_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nand_cle_o, nand_ale_o}));
  // R9: chip enable releases together with the acknowledge
  a_r9_ce_release_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nand_ce_no) |-> ack_o);
  // R6: bus never driven while reading
  a_r6_no_drive_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o);
endmodule

// File: tb/nand_strobe_ctrl_test.sv
module nand_strobe_ctrl_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = '0;
  logic        req = 1'b0;
  logic [1:0]  kind = 2'd0;
  logic [7:0]  wdata = '0;
  logic        ack, ready;
  logic [7:0]  rdata;
  logic        ce_n, we_n, re_n, cle, ale, dq_oe;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i = '0;
  logic        rb = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic tb_prev_vld = 1'b0;
  logic tb_prev_rd  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_strobe_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .req_i(req), .kind_i(kind),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .ready_o(ready),
    .nand_ce_no(ce_n), .nand_we_no(we_n), .nand_re_no(re_n),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_dq_o(dq_o),
    .nand_dq_oe_o(dq_oe), .nand_dq_i(dq_i), .nand_rb_i(rb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one access; entered and left at a falling edge
  task automatic access(input logic [1:0] k, input logic [7:0] v,
                        input int wsu, input int wst, input int whd,
                        input int rsu, input int rst, input int rhd, input int ta);
    int n = 0, pre = 0, su = 0, st = 0, hd = 0, bad = 0, ph = 0;
    int xsu, xst, xhd, xpre;
    logic is_rd;
    is_rd = (k == 2'd3);
    cfg   = (32'(wsu) << 26) | (32'(wst) << 20) | (32'(whd) << 17) |
            (32'(rsu) << 13) | (32'(rst) << 7)  | (32'(rhd) << 4)  | (32'(ta) << 2);
    kind  = k;
    wdata = v;
    req   = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      if (n == 2) begin kind = ~k; wdata = ~v; end  // R9: ignored while busy
      if (ack || n > 400) break;
      if (ce_n) begin
        if (ph == 0 && su == 0) pre++;
        else bad |= 1;
      end else if (!we_n || !re_n) begin
        ph = 1; st++;
        if (is_rd) begin
          if (!we_n || dq_oe) bad |= 2;
          dq_i = v ^ 8'(st - 1);
        end else begin
          if (!re_n || !dq_oe || dq_o != v) bad |= 4;
        end
        if (cle != (k == 2'd0) || ale != (k == 2'd1)) bad |= 8;
      end else begin
        if (ph == 0) su++; else hd++;
        if (cle != (k == 2'd0) || ale != (k == 2'd1)) bad |= 8;
        if (dq_oe == is_rd) bad |= 16;
      end
    end
    req = 1'b0;
    xsu  = (is_rd ? rsu : wsu) + 1;
    xst  = (is_rd ? rst : wst) + 1;
    xhd  = (is_rd ? rhd : whd) + 1;
    xpre = (tb_prev_vld && tb_prev_rd != is_rd) ? ta + 1 : 0;
    chk(is_rd ? "R4 setup cycles" : "R3 setup cycles", su, xsu);
    chk(is_rd ? "R4 strobe cycles" : "R3 strobe cycles", st, xst);
    chk(is_rd ? "R4 hold cycles" : "R3 hold cycles", hd, xhd);
    chk("R8 idle cycles before access", pre, xpre);
    chk("R5/R6 pin levels during access (bitmask)", bad, 0);
    chk("R9 ack cycle", n, xpre + xsu + xst + xhd + 1);
    if (is_rd) chk("R7 captured byte", int'(rdata), int'(v ^ 8'(rst)));
    @(negedge clk);
    chk("R9 ack single pulse", int'(ack), 0);
    chk("R9 no restart after ack", int'(ce_n), 1);
    tb_prev_vld = 1'b1;
    tb_prev_rd  = is_rd;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int sel_w[3] = '{0, 2, 3};
    int sel_r[3] = '{0, 1, 5};
    rb = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 ce in reset", int'(ce_n), 1);
    chk("R1 ready in reset", int'(ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes idle", int'({we_n, re_n}), 3);
    chk("R1 latch enables low", int'({cle, ale}), 0);
    chk("R1 bus released, no ack", int'({dq_oe, ack}), 0);
    chk("R10 ready after one stage", int'(ready), 0);
    @(negedge clk);
    chk("R10 ready after two stages", int'(ready), 1);
    rb = 1'b0;
    @(negedge clk);
    chk("R10 busy after one stage", int'(ready), 1);
    @(negedge clk);
    chk("R10 busy after two stages", int'(ready), 0);

    // R2: nominal configuration word
    access(2'd0, 8'h70, 1, 3, 1, 1, 5, 1, 3);
    access(2'd3, 8'hE0, 1, 3, 1, 1, 5, 1, 3);
    // R2: all fields at maximum
    access(2'd2, 8'h5A, 15, 63, 7, 15, 63, 7, 3);
    access(2'd3, 8'hA5, 15, 63, 7, 15, 63, 7, 3);

    // sweep of small field values and kind orderings
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 2; c++)
          for (int t = 0; t < 4; t++) begin
            access(2'd0, 8'(8'h10 + a),     a, sel_w[b], c, 2 - a, sel_r[b], 1 - c, t);
            access(2'd1, 8'(8'h20 + b),     a, sel_w[b], c, 2 - a, sel_r[b], 1 - c, t);
            access(2'd2, 8'(8'h30 + t),     a, sel_w[b], c, 2 - a, sel_r[b], 1 - c, t);
            access(2'd3, 8'(8'hC0 + a * 4), a, sel_w[b], c, 2 - a, sel_r[b], 1 - c, t);
            access(2'd3, 8'(8'h81 + c),     a, sel_w[b], c, 2 - a, sel_r[b], 1 - c, t);
            access(2'd1, 8'(8'h44 + t),     a, sel_w[b], c, 2 - a, sel_r[b], 1 - c, t);
          end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule